// File: doc/BRIEF.md
# Chained Device Address Decoder

This block sits at the access side of a queue device that can be chained with up to seven others on shared address and output buses. Each write or read address is five bits wide. The upper three bits name a device and the lower two bits name one of four queues inside it. The block compares the device field with a device number taken at master reset. It reports a write hit with its queue index. It also tracks which device currently owns the shared read-data outputs. The queue storage and the flag logic live elsewhere.

Master reset is an active-low pulse on `mrst_n`. While it is low, the block samples its device number, its master/slave role and its input-width choice on every clock edge. It holds all three once reset is released. After reset the master device owns the output bus and every slave releases it. After that, the device named by the latest read selection owns the bus and every other device gives it up. A null-queue selection lets the addressed device drop its current read queue without starting a read from any queue. The output enable is a plain level input that gates the owner's drivers with no clock involved. No data moves through this block, so every pin is a plain control or status signal and there is no valid/ready handshake.

Top module: `chain_addr_decode`

## Requirements
- R1: One clock after an edge where `wr_sel` is high and `wr_addr[4:2]` equals the captured device number, `wr_hit` is 1 and `wr_queue` equals `wr_addr[1:0]`.
- R2: A write whose device field differs from the captured number gives `wr_hit` = 0 one clock later. Across a chain of eight devices with distinct numbers 0 to 7, every write address hits exactly one device.
- R3: While `mrst_n` is low, `dev_num`, `is_master` and `narrow_bus` follow `cfg_num`, `cfg_master` and `cfg_width` at each clock edge. After release they keep those values whatever the configuration inputs do.
- R4: `narrow_bus` = 1 (9-bit input bus) when `cfg_width` was high during reset, and 0 (18-bit input bus) when it was low.
- R5: Right after reset, `bus_owner` equals the captured master role: 1 on the master and 0 on a slave.
- R6: One clock after an edge where `rd_sel` is high, `rd_null_sel` is low and `rd_addr[4:2]` matches, `bus_owner` = 1, `rd_valid` = 1, `rd_hit` = 1 and `rd_queue` = `rd_addr[1:0]`.
- R7: One clock after an edge where `rd_sel` is high and `rd_addr[4:2]` does not match, `bus_owner` = 0 and `rd_valid` = 0, whether or not the null queue is selected.
- R8: One clock after an edge where `rd_sel` and `rd_null_sel` are high and the device field matches, `rd_null` = 1, `rd_hit` = 0, `rd_valid` = 0 and `bus_owner` = 1.
- R9: `out_drive` = `bus_owner` AND NOT `oe_n`. It follows `oe_n` with no clock edge.
- R10: In a chain of eight devices sharing all inputs, at most one `out_drive` is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for address sampling and ownership |
| mrst_n | input | 1 | Master reset, active low |
| cfg_num | input | 3 | Device number sampled during reset |
| cfg_master | input | 1 | Role sampled during reset, 1 = master |
| cfg_width | input | 1 | Width choice sampled during reset, 1 = 9-bit |
| wr_sel | input | 1 | Write address enable |
| wr_addr | input | 5 | Write address: device field [4:2], queue [1:0] |
| rd_sel | input | 1 | Read address enable |
| rd_addr | input | 5 | Read address: device field [4:2], queue [1:0] |
| rd_null_sel | input | 1 | Selects the null queue together with `rd_sel` |
| oe_n | input | 1 | Output enable, active low, unclocked |
| dev_num | output | 3 | Captured device number |
| is_master | output | 1 | Captured master role |
| narrow_bus | output | 1 | Captured width, 1 = 9-bit input bus |
| wr_hit | output | 1 | Write addressed this device |
| wr_queue | output | 2 | Queue index of the last write hit |
| rd_hit | output | 1 | Real read queue selected on this device |
| rd_null | output | 1 | Null queue selected on this device |
| rd_valid | output | 1 | A real read queue is currently held |
| rd_queue | output | 2 | Queue index of the held read queue |
| bus_owner | output | 1 | This device owns the shared outputs |
| out_drive | output | 1 | Output drivers enabled |

## Verification
The bench builds the block with its default widths: a 3-bit device field and a 2-bit queue field. These widths give exactly eight device numbers, so an exhaustive sweep of all 32 write addresses over a chain of eight instances is small enough to run. That sweep covers both matching and non-matching device fields. It also lets the bench check that ownership is exclusive across the whole chain. It places the master at a device number other than zero to show that the number and the chain position are independent.

// File: rtl/cad_pkg.sv
package cad_pkg;
  parameter int DEV_W = 3;
  parameter int QSEL_W = 2;
  localparam int ADDR_W = DEV_W + QSEL_W;
endpackage

// File: rtl/cad_cfg_latch.sv
module cad_cfg_latch #(
  parameter int DEV_W = 3
) (
  input  logic             clk,
  input  logic             mrst_n,
  input  logic [DEV_W-1:0] cfg_num,
  input  logic             cfg_master,
  input  logic             cfg_width,
  output logic [DEV_W-1:0] dev_num,
  output logic             is_master,
  output logic             narrow_bus
);
  // Sampled on every edge while reset is low; frozen afterwards.
  always_ff @(posedge clk) begin
    if (!mrst_n) begin
      dev_num    <= cfg_num;
      is_master  <= cfg_master;
      narrow_bus <= cfg_width;
    end
  end
endmodule

// File: rtl/cad_addr_match.sv
module cad_addr_match #(
  parameter int DEV_W  = 3,
  parameter int QSEL_W = 2,
  localparam int ADDR_W = DEV_W + QSEL_W
) (
  input  logic              sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DEV_W-1:0]  dev_num,
  output logic              hit,
  output logic              miss,
  output logic [QSEL_W-1:0] queue
);
  logic field_eq;
  assign field_eq = (addr[ADDR_W-1:QSEL_W] == dev_num);
  assign hit   = sel && field_eq;
  assign miss  = sel && !field_eq;
  assign queue = addr[QSEL_W-1:0];
endmodule

// File: rtl/cad_bus_owner.sv
module cad_bus_owner #(
  parameter int QSEL_W = 2
) (
  input  logic              clk,
  input  logic              mrst_n,
  input  logic              cfg_master,
  input  logic              rd_match,
  input  logic              rd_mismatch,
  input  logic              null_sel,
  input  logic [QSEL_W-1:0] rd_q_in,
  output logic              owner,
  output logic              rd_valid,
  output logic              rd_hit,
  output logic              rd_null,
  output logic [QSEL_W-1:0] rd_queue
);
  always_ff @(posedge clk) begin
    if (!mrst_n) begin
      owner    <= cfg_master;
      rd_valid <= 1'b0;
      rd_hit   <= 1'b0;
      rd_null  <= 1'b0;
      rd_queue <= '0;
    end else begin
      rd_hit  <= rd_match && !null_sel;
      rd_null <= rd_match && null_sel;
      if (rd_match) begin
        owner    <= 1'b1;
        rd_valid <= !null_sel;
        if (!null_sel) rd_queue <= rd_q_in;
      end else if (rd_mismatch) begin
        owner    <= 1'b0;
        rd_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/chain_addr_decode.sv
module chain_addr_decode
  import cad_pkg::*;
#(
  parameter int DW = cad_pkg::DEV_W,
  parameter int QW = cad_pkg::QSEL_W,
  localparam int AW = DW + QW
) (
  input  logic          clk,
  input  logic          mrst_n,
  input  logic [DW-1:0] cfg_num,
  input  logic          cfg_master,
  input  logic          cfg_width,
  input  logic          wr_sel,
  input  logic [AW-1:0] wr_addr,
  input  logic          rd_sel,
  input  logic [AW-1:0] rd_addr,
  input  logic          rd_null_sel,
  input  logic          oe_n,
  output logic [DW-1:0] dev_num,
  output logic          is_master,
  output logic          narrow_bus,
  output logic          wr_hit,
  output logic [QW-1:0] wr_queue,
  output logic          rd_hit,
  output logic          rd_null,
  output logic          rd_valid,
  output logic [QW-1:0] rd_queue,
  output logic          bus_owner,
  output logic          out_drive
);
  logic          w_match, w_miss, r_match, r_miss;
  logic [QW-1:0] w_q, r_q;

  cad_cfg_latch #(.DEV_W(DW)) u_cfg (
    .clk(clk), .mrst_n(mrst_n), .cfg_num(cfg_num), .cfg_master(cfg_master),
    .cfg_width(cfg_width), .dev_num(dev_num), .is_master(is_master),
    .narrow_bus(narrow_bus)
  );

  cad_addr_match #(.DEV_W(DW), .QSEL_W(QW)) u_wmatch (
    .sel(wr_sel), .addr(wr_addr), .dev_num(dev_num),
    .hit(w_match), .miss(w_miss), .queue(w_q)
  );

  cad_addr_match #(.DEV_W(DW), .QSEL_W(QW)) u_rmatch (
    .sel(rd_sel), .addr(rd_addr), .dev_num(dev_num),
    .hit(r_match), .miss(r_miss), .queue(r_q)
  );

  cad_bus_owner #(.QSEL_W(QW)) u_owner (
    .clk(clk), .mrst_n(mrst_n), .cfg_master(cfg_master),
    .rd_match(r_match), .rd_mismatch(r_miss), .null_sel(rd_null_sel),
    .rd_q_in(r_q), .owner(bus_owner), .rd_valid(rd_valid),
    .rd_hit(rd_hit), .rd_null(rd_null), .rd_queue(rd_queue)
  );

  always_ff @(posedge clk) begin
    if (!mrst_n) begin
      wr_hit   <= 1'b0;
      wr_queue <= '0;
    end else begin
      wr_hit <= w_match;
      if (w_match) wr_queue <= w_q;
    end
  end

  // Unclocked gate: the enable reaches the drivers without a register.
  assign out_drive = bus_owner && !oe_n;

  logic unused_miss;
  assign unused_miss = w_miss;
endmodule

// File: rtl/cad_checker.sv
module cad_checker #(
  parameter int DW = 3,
  parameter int QW = 2,
  localparam int AW = DW + QW
) (
  input logic          clk,
  input logic          mrst_n,
  input logic          wr_sel,
  input logic [AW-1:0] wr_addr,
  input logic          rd_sel,
  input logic [AW-1:0] rd_addr,
  input logic          rd_null_sel,
  input logic [DW-1:0] dev_num,
  input logic          is_master,
  input logic          narrow_bus,
  input logic          wr_hit,
  input logic [QW-1:0] wr_queue,
  input logic          rd_hit,
  input logic          rd_null,
  input logic          rd_valid,
  input logic [QW-1:0] rd_queue,
  input logic          bus_owner,
  input logic          out_drive
);
  logic wmatch, rmatch;
  assign wmatch = wr_addr[AW-1:QW] == dev_num;
  assign rmatch = rd_addr[AW-1:QW] == dev_num;

  p_wr_hit_r1: assert property (@(posedge clk) disable iff (!mrst_n)
    wr_sel && wmatch |=> wr_hit && (wr_queue == $past(wr_addr[QW-1:0])));

  p_wr_miss_r2: assert property (@(posedge clk) disable iff (!mrst_n)
    wr_sel && !wmatch |=> !wr_hit);

  p_cfg_hold_r3: assert property (@(posedge clk) disable iff (!mrst_n)
    1'b1 |=> $stable(dev_num) && $stable(is_master) && $stable(narrow_bus));

  p_rd_take_r6: assert property (@(posedge clk) disable iff (!mrst_n)
    rd_sel && rmatch && !rd_null_sel |=> bus_owner && rd_valid && rd_hit);

  p_rd_release_r7: assert property (@(posedge clk) disable iff (!mrst_n)
    rd_sel && !rmatch |=> !bus_owner && !rd_valid);

  p_null_sel_r8: assert property (@(posedge clk) disable iff (!mrst_n)
    rd_sel && rmatch && rd_null_sel |=> rd_null && !rd_hit && !rd_valid && bus_owner);

  p_drive_owner_r9: assert property (@(posedge clk) disable iff (!mrst_n)
    out_drive |-> bus_owner);
endmodule

bind chain_addr_decode cad_checker #(.DW(DW), .QW(QW)) u_chk (
  .clk(clk), .mrst_n(mrst_n), .wr_sel(wr_sel), .wr_addr(wr_addr),
  .rd_sel(rd_sel), .rd_addr(rd_addr), .rd_null_sel(rd_null_sel),
  .dev_num(dev_num), .is_master(is_master), .narrow_bus(narrow_bus),
  .wr_hit(wr_hit), .wr_queue(wr_queue), .rd_hit(rd_hit), .rd_null(rd_null),
  .rd_valid(rd_valid), .rd_queue(rd_queue), .bus_owner(bus_owner),
  .out_drive(out_drive)
);

// File: tb/chain_addr_decode_bench.sv
module chain_addr_decode_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       mrst_n = 1'b0;
  logic [2:0] cfg_num = 3'd5;
  logic       cfg_master = 1'b0, cfg_width = 1'b1;
  logic       wr_sel = 0, rd_sel = 0, rd_null_sel = 0, oe_n = 1'b1;
  logic [4:0] wr_addr = '0, rd_addr = '0;
  logic [2:0] dev_num;
  logic       is_master, narrow_bus, wr_hit, rd_hit, rd_null, rd_valid, bus_owner, out_drive;
  logic [1:0] wr_queue, rd_queue;

  int tests = 0, fails = 0;

  chain_addr_decode u_chain_addr_decode (
    .clk(clk), .mrst_n(mrst_n), .cfg_num(cfg_num), .cfg_master(cfg_master),
    .cfg_width(cfg_width), .wr_sel(wr_sel), .wr_addr(wr_addr), .rd_sel(rd_sel),
    .rd_addr(rd_addr), .rd_null_sel(rd_null_sel), .oe_n(oe_n),
    .dev_num(dev_num), .is_master(is_master), .narrow_bus(narrow_bus),
    .wr_hit(wr_hit), .wr_queue(wr_queue), .rd_hit(rd_hit), .rd_null(rd_null),
    .rd_valid(rd_valid), .rd_queue(rd_queue), .bus_owner(bus_owner),
    .out_drive(out_drive)
  );

  // Chain of eight: instance k has number 7-k; instance 2 (number 5) is master.
  logic [7:0] c_hit, c_drive;
  for (genvar k = 0; k < 8; k++) begin : g_chain
    logic [2:0] n_o; logic m_o, w_o, rh_o, rn_o, rv_o, bo_o;
    logic [1:0] wq_o, rq_o;
    chain_addr_decode u_dev (
      .clk(clk), .mrst_n(mrst_n), .cfg_num(3'(7 - k)), .cfg_master(k == 2),
      .cfg_width(1'b0), .wr_sel(wr_sel), .wr_addr(wr_addr), .rd_sel(rd_sel),
      .rd_addr(rd_addr), .rd_null_sel(rd_null_sel), .oe_n(oe_n),
      .dev_num(n_o), .is_master(m_o), .narrow_bus(w_o),
      .wr_hit(c_hit[k]), .wr_queue(wq_o), .rd_hit(rh_o), .rd_null(rn_o),
      .rd_valid(rv_o), .rd_queue(rq_o), .bus_owner(bo_o), .out_drive(c_drive[k])
    );
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic we; logic [4:0] wa; logic re; logic [4:0] ra; logic nl;
    logic e_wh; logic [1:0] e_wq; logic e_own; logic e_val; logic [1:0] e_rq; logic e_nul;
  } vec_t;

  // Device number 5: matching addresses are 20..23.
  localparam vec_t VEC [8] = '{
    '{1'b1, 5'd21, 1'b0, 5'd0,  1'b0, 1'b1, 2'd1, 1'b0, 1'b0, 2'd0, 1'b0},
    '{1'b1, 5'd9,  1'b0, 5'd0,  1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 1'b0},
    '{1'b0, 5'd0,  1'b1, 5'd23, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1, 2'd3, 1'b0},
    '{1'b1, 5'd22, 1'b0, 5'd0,  1'b0, 1'b1, 2'd2, 1'b1, 1'b1, 2'd3, 1'b0},
    '{1'b0, 5'd0,  1'b1, 5'd20, 1'b1, 1'b0, 2'd0, 1'b1, 1'b0, 2'd0, 1'b1},
    '{1'b0, 5'd0,  1'b1, 5'd4,  1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 1'b0},
    '{1'b0, 5'd0,  1'b1, 5'd22, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1, 2'd2, 1'b0},
    '{1'b0, 5'd0,  1'b1, 5'd12, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 1'b0}
  };

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    mrst_n = 1'b1;
    @(negedge clk);
    // Reset state and captured settings
    chk("R3 dev_num", dev_num, 5);
    chk("R5 slave owner", bus_owner, 0);
    chk("R4 narrow", narrow_bus, 1);
    chk("R5 chain master owner", c_drive == 8'd0 ? 1 : 0, 1);
    cfg_num = 3'd2; cfg_master = 1'b1; cfg_width = 1'b0;
    repeat (2) @(negedge clk);
    chk("R3 hold num", dev_num, 5);
    chk("R3 hold role", is_master, 0);
    chk("R3 hold width", narrow_bus, 1);

    for (int i = 0; i < 8; i++) begin
      wr_sel = VEC[i].we; wr_addr = VEC[i].wa;
      rd_sel = VEC[i].re; rd_addr = VEC[i].ra; rd_null_sel = VEC[i].nl;
      @(negedge clk);
      chk(VEC[i].e_wh ? "R1 wr_hit" : "R2 wr_hit", wr_hit, VEC[i].e_wh);
      if (VEC[i].e_wh) chk("R1 wr_queue", wr_queue, VEC[i].e_wq);
      chk(VEC[i].e_own ? "R6 owner" : "R7 owner", bus_owner, VEC[i].e_own);
      chk(VEC[i].e_val ? "R6 rd_valid" : "R7 rd_valid", rd_valid, VEC[i].e_val);
      if (VEC[i].e_val) chk("R6 rd_queue", rd_queue, VEC[i].e_rq);
      chk("R8 rd_null", rd_null, VEC[i].e_nul);
      if (VEC[i].e_nul) chk("R8 rd_hit", rd_hit, 0);
      if (VEC[i].re && VEC[i].e_val) chk("R6 rd_hit", rd_hit, 1);
      if (c_drive != 8'd0) chk("R10 exclusive", $countones(c_drive), 1);
    end
    wr_sel = 0; rd_sel = 0; rd_null_sel = 0;

    // Output enable acts without a clock edge (DUT owns bus from vector 7, cleared by vector 8)
    rd_sel = 1; rd_addr = 5'd21;
    @(negedge clk); rd_sel = 0;
    chk("R6 owner again", bus_owner, 1);
    oe_n = 1'b0; #1;
    chk("R9 drive on", out_drive, 1);
    oe_n = 1'b1; #1;
    chk("R9 drive off", out_drive, 0);
    oe_n = 1'b0;

    // Write sweep over chain: each address hits exactly the device numbered addr[4:2]
    for (int a = 0; a < 32; a++) begin
      @(negedge clk); wr_sel = 1; wr_addr = 5'(a);
      @(negedge clk); wr_sel = 0;
      chk("R2 one hit", $countones(c_hit), 1);
      chk("R2 right device", c_hit[7 - (a >> 2)], 1);
    end

    // Read ownership walk across the chain with drivers enabled
    for (int a = 0; a < 32; a++) begin
      @(negedge clk); rd_sel = 1; rd_addr = 5'((a * 13) % 32); rd_null_sel = (a % 5 == 0);
      @(negedge clk); rd_sel = 0; rd_null_sel = 0;
      chk("R10 exactly one drives", $countones(c_drive), 1);
    end

    // Second reset: new configuration captured, master owns at once
    @(negedge clk); mrst_n = 1'b0; cfg_num = 3'd0; cfg_master = 1'b1; cfg_width = 1'b0;
    repeat (2) @(negedge clk); mrst_n = 1'b1;
    @(negedge clk);
    chk("R3 recapture num", dev_num, 0);
    chk("R4 wide bus", narrow_bus, 0);
    chk("R5 master owner", bus_owner, 1);
    chk("R9 master drives", out_drive, 1);
    chk("R10 chain after reset", $countones(c_drive), 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule